// File: doc/BRIEF.md
# Floppy Drive Control Latches

This block holds two write-only byte registers that sit next to a floppy disk controller. The drive register picks one of three drives and sets the spindle motor line. The controller register drives the controller's reset and density inputs. It also carries six head and step control bits, which pass through without change.

A host writes a byte with `wr_en` high. `wr_sel` picks the register. Every output is a flop and changes on the clock edge that accepts the write. Reset clears both registers. After reset no drive is selected, the motor is off and the disk controller is held in reset until software sets the release bit.

Top module: `fdd_ctl_latch`

## Requirements
- R1: `wr_sel` = 0 writes the drive register and `wr_sel` = 1 writes the controller register. A write to one register leaves the outputs of the other unchanged.
- R2: Drive register bits 0, 1 and 2 request drives 0, 1 and 2. `drv_sel` is one-hot, and when more than one bit is set the highest-numbered requested drive is selected.
- R3: A drive register write with bits 0 to 2 all zero deselects every drive (`drv_sel` = 0).
- R4: While a drive is selected, `motor_on_n` is the inverse of drive register bit 3. While no drive is selected, `motor_on_n` is 1.
- R5: `fdc_reset` is 1 while controller register bit 0 is 0. It stays 1 until a write sets that bit, and it is 0 from the clock after that write.
- R6: `density` equals controller register bit 1.
- R7: `head_ctl[5:0]` equals controller register bits 7 down to 2, with bit 2 on `head_ctl[0]`.
- R8: After `rst`: `drv_sel` = 0, `motor_on_n` = 1, `fdc_reset` = 1, `density` = 0, `head_ctl` = 0.
- R9: The outputs take a written value on the clock edge that samples `wr_en`. With `wr_en` low they hold.
- R10: Drive register bits 4 to 7 affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | 0 = drive register, 1 = controller register |
| wr_data | input | 8 | Byte to write |
| drv_sel | output | 3 | One-hot drive select |
| motor_on_n | output | 1 | Motor-on to the selected drive, active low |
| fdc_reset | output | 1 | Disk controller reset, active high |
| density | output | 1 | Density select level |
| head_ctl | output | 6 | Pass-through head and step control bits |

## Verification
The bench writes every combination of the three select bits, with the motor bit both set and clear. A design that used lowest-wins priority, or that passed the raw select bits through, would show two drives selected or the wrong drive. It also checks that the motor stays off when no drive is selected, and that drive register bits 4 to 7 cannot disturb anything.

The bench also watches the reset line across many idle cycles and across writes to the drive register. A design that pulsed the reset for one cycle, or that let a drive-register write leak into the controller register, would release the reset early or corrupt the density and head bits. A reset in the middle of the run checks that the cleared state comes back.

// File: rtl/fdd_ctl_pkg.sv
package fdd_ctl_pkg;
  typedef enum logic {
    REG_DRIVE = 1'b0,
    REG_CTRL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/fdd_sel_prio.sv
module fdd_sel_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_lane
      if (i == N-1) begin : g_top
        assign grant[i] = req[i];
      end else begin : g_low
        assign grant[i] = req[i] & ~(|req[N-1:i+1]);
      end
    end
  endgenerate
endmodule

// File: rtl/fdd_drive_latch.sv
module fdd_drive_latch #(
  parameter int DATA_W     = 8,
  parameter int NUM_DRIVES = 3,
  parameter int MOTOR_BIT  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [DATA_W-1:0]     data,
  output logic [NUM_DRIVES-1:0] drv_sel,
  output logic                  motor_on_n
);
  localparam logic [NUM_DRIVES-1:0] TOP_ONLY = NUM_DRIVES'(1) << (NUM_DRIVES-1);

  logic [NUM_DRIVES-1:0] grant;
  logic unused_hi;
  assign unused_hi = ^data[DATA_W-1:MOTOR_BIT+1];

  fdd_sel_prio #(.N(NUM_DRIVES)) u_prio (
    .req   (data[NUM_DRIVES-1:0]),
    .grant (grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_sel    <= '0;
      motor_on_n <= 1'b1;
    end else if (wr) begin
      drv_sel    <= grant;
      motor_on_n <= (|grant) ? ~data[MOTOR_BIT] : 1'b1;
    end
  end

  AST_HIGH_WINS: assert property (@(posedge clk) disable iff (rst)
    wr && data[NUM_DRIVES-1] |=> drv_sel == TOP_ONLY); // R2
  AST_NONE_SEL: assert property (@(posedge clk) disable iff (rst)
    wr && (data[NUM_DRIVES-1:0] == '0) |=> drv_sel == '0); // R3
  AST_MOTOR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (drv_sel == '0) |-> motor_on_n); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(drv_sel) && $stable(motor_on_n)); // R9
endmodule

// File: rtl/fdd_ctrl_latch.sv
module fdd_ctrl_latch #(
  parameter int DATA_W  = 8,
  parameter int RST_BIT = 0,
  parameter int DEN_BIT = 1,
  parameter int AUX_LO  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [DATA_W-1:0]        data,
  output logic                     fdc_reset,
  output logic                     density,
  output logic [DATA_W-AUX_LO-1:0] aux
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fdc_reset <= 1'b1;
      density   <= 1'b0;
      aux       <= '0;
    end else if (wr) begin
      fdc_reset <= ~data[RST_BIT];
      density   <= data[DEN_BIT];
      aux       <= data[DATA_W-1:AUX_LO];
    end
  end

  AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(fdc_reset)); // R5
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    wr && data[RST_BIT] |=> !fdc_reset); // R5
  AST_DEN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    wr |=> density == $past(data[DEN_BIT])); // R6
endmodule

// File: rtl/fdd_ctl_latch.sv
module fdd_ctl_latch
  import fdd_ctl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_DRIVES = 3,
  parameter int MOTOR_BIT  = 3,
  parameter int AUX_LO     = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_DRIVES-1:0]    drv_sel,
  output logic                     motor_on_n,
  output logic                     fdc_reset,
  output logic                     density,
  output logic [DATA_W-AUX_LO-1:0] head_ctl
);
  logic wr_drive, wr_ctrl;
  assign wr_drive = wr_en && (reg_sel_e'(wr_sel) == REG_DRIVE);
  assign wr_ctrl  = wr_en && (reg_sel_e'(wr_sel) == REG_CTRL);

  fdd_drive_latch #(
    .DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES), .MOTOR_BIT(MOTOR_BIT)
  ) u_drive (
    .clk(clk), .rst(rst), .wr(wr_drive), .data(wr_data),
    .drv_sel(drv_sel), .motor_on_n(motor_on_n)
  );

  fdd_ctrl_latch #(
    .DATA_W(DATA_W), .RST_BIT(0), .DEN_BIT(1), .AUX_LO(AUX_LO)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctrl), .data(wr_data),
    .fdc_reset(fdc_reset), .density(density), .aux(head_ctl)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> fdc_reset && (drv_sel == '0) && motor_on_n); // R8
  AST_CTRL_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    wr_drive |=> $stable(fdc_reset) && $stable(density) && $stable(head_ctl)); // R1
endmodule

// File: tb/sim_fdd_ctl_latch.sv
module sim_fdd_ctl_latch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] drv_sel;
  logic motor_on_n, fdc_reset, density;
  logic [5:0] head_ctl;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  int m0 = 0;
  int m1 = 0;

  always #10 clk = ~clk;

  fdd_ctl_latch u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .drv_sel(drv_sel), .motor_on_n(motor_on_n), .fdc_reset(fdc_reset),
    .density(density), .head_ctl(head_ctl)
  );

  // behavioural reference: register contents
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m0 <= 0;
      m1 <= 0;
    end else if (wr_en) begin
      if (wr_sel) m1 <= int'(wr_data);
      else        m0 <= int'(wr_data);
    end
  end

  function automatic int exp_sel(int r0);
    for (int d = 2; d >= 0; d--)
      if (((r0 >> d) & 1) == 1) return (1 << d);
    return 0;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h at cycle %0d", req, got, exp, cycles);
    end
  endtask

  // cycle-by-cycle compare against the model
  always @(negedge clk) begin
    if (!done) begin
      int es;
      es = exp_sel(m0);
      chk((m0 & 7) == 0 ? "R3 sel" : "R2 sel", int'(drv_sel), es);
      chk("R4 motor", int'(motor_on_n), (es == 0) ? 1 : (((m0 >> 3) & 1) ^ 1));
      chk("R5 reset", int'(fdc_reset), (m1 & 1) ^ 1);
      chk("R6 dens", int'(density), (m1 >> 1) & 1);
      chk("R7 head", int'(head_ctl), (m1 >> 2) & 63);
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk("R8 sel", int'(drv_sel), 0);
    chk("R8 motor", int'(motor_on_n), 1);
    chk("R8 reset", int'(fdc_reset), 1);
    chk("R8 dens", int'(density), 0);
    chk("R8 head", int'(head_ctl), 0);
    // R5 reset held with no writes
    idle(20);
    chk("R5 held", int'(fdc_reset), 1);
    // R2 R4 all select combinations with and without motor bit
    for (int v = 0; v < 16; v++) begin
      wr(1'b0, 8'(v));
      idle(1);
    end
    wr(1'b0, 8'h07);
    chk("R2 top wins", int'(drv_sel), 4);
    chk("R4 motor off", int'(motor_on_n), 1);
    wr(1'b0, 8'h0B);
    chk("R2 mid wins", int'(drv_sel), 2);
    chk("R4 motor on", int'(motor_on_n), 0);
    wr(1'b0, 8'h08);
    chk("R3 none", int'(drv_sel), 0);
    chk("R4 idle", int'(motor_on_n), 1);
    // R10 high bits of the drive register do nothing
    wr(1'b0, 8'h09);
    wr(1'b0, 8'hF9);
    chk("R10 sel", int'(drv_sel), 1);
    chk("R10 motor", int'(motor_on_n), 0);
    chk("R10 reset", int'(fdc_reset), 1);
    // R5 release, R6 density, R7 head bits
    wr(1'b1, 8'hA7);
    chk("R5 release", int'(fdc_reset), 0);
    chk("R6 dens", int'(density), 1);
    chk("R7 head", int'(head_ctl), 6'h29);
    // R1 drive writes leave controller outputs alone
    wr(1'b0, 8'h04);
    chk("R1 ctrl kept", int'(head_ctl), 6'h29);
    chk("R1 sel", int'(drv_sel), 4);
    // R1 controller writes leave drive outputs alone
    wr(1'b1, 8'h5C);
    chk("R1 drive kept", int'(drv_sel), 4);
    chk("R5 reassert", int'(fdc_reset), 1);
    // R9 hold and same-edge update
    idle(10);
    chk("R9 hold", int'(head_ctl), 6'h17);
    for (int v = 0; v < 256; v += 37) begin
      wr(1'b1, 8'(v));
      wr(1'b0, 8'(v ^ 8'h5A));
    end
    // R8 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 mid sel", int'(drv_sel), 0);
    chk("R8 mid reset", int'(fdc_reset), 1);
    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule